// File: doc/BRIEF.md
# Simple Dual-Port RAM with Selectable Read-During-Write Policy

This block is a synchronous memory with one write port and one read port, both clocked by a single edge. The read data is registered. It appears one clock after the read address and read enable are sampled. The storage array has no reset. Only the read output register is cleared.

The block has a parameter that sets what the read port returns when it reads the word being written in the same cycle. Three results are available: the contents from before the write (the default), the data being written, or a value marked unknown. A separate output flag marks the unknown case, so logic downstream can detect it without relying on simulator X values.

A second parameter builds the block as a single-port memory. In that form, one address (the write address port) serves both read and write, and the read address input has no effect. The newly-written-data policy is only guaranteed in the single-port form. When it is requested in the dual-port form, a collision is reported as unknown.

Top module: `dpram_rdw`

## Requirements
- R1: After reset, `rd_data` is 0 and `rd_unknown` is 0.
- R2: When `rd_en` is high at a clock edge, the word at the read address is on `rd_data` after that edge, and `rd_unknown` is 0 unless R6 to R9 apply.
- R3: While `rd_en` is low at an edge, `rd_data` and `rd_unknown` keep their values.
- R4: A write takes place only when `wr_en` is high at the edge. With `wr_en` low, the addressed word is unchanged.
- R5: A write to one address never changes the value read from a different address in the same cycle, whatever the policy.
- R6: With the old-data policy, a collision (read and write to the same address with both enables high) returns the word stored before the write, and `rd_unknown` stays 0.
- R7: With the unknown policy, a collision sets `rd_unknown` to 1 and drives X on `rd_data`. The array still stores the write, so a later read of that address returns the written value.
- R8: In the single-port form with the new-data policy, a collision returns `wr_data` of that cycle.
- R9: In the dual-port form, a new-data request on a collision is reported as unknown (`rd_unknown` = 1).
- R10: In the single-port form, the read uses `wr_addr` and `rd_addr` has no effect.
- R11: `rd_unknown` returns to 0 on the next enabled read that is not a collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address (also the read address in single-port form) |
| wr_data | input | DATA_W | Data to store |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address (dual-port form only) |
| rd_data | output | DATA_W | Registered read data |
| rd_unknown | output | 1 | High when rd_data holds an unknown collision result |

## Verification
The bench drives four instances in parallel: dual-port old-data, dual-port unknown, single-port new-data and dual-port new-data. It aims at same-address collisions, including back-to-back ones. A policy decoded wrongly would return stale data where new data was due, or the reverse. Reads that follow an unknown collision expose a design that skips the array write or leaves the unknown flag stuck. Cycles with the read disabled, and same-cycle writes to other addresses, catch an output register that loads when it should hold or a read that sees the write. In the single-port instance, `rd_addr` differs from `wr_addr`, which exposes a design that reads from the wrong address.

// File: rtl/ram_pkg.sv
package ram_pkg;
   typedef enum logic [1:0] {
      RDW_OLD = 2'd0,
      RDW_NEW = 2'd1,
      RDW_UNK = 2'd2
   } rdw_policy_e;
endpackage

// File: rtl/ram_array.sv
module ram_array #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rword
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   // storage has no reset, like a hard memory macro
   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   // value held before this edge's write
   assign rword = store[raddr];
endmodule

// File: rtl/ram_collide.sv
module ram_collide
   import ram_pkg::*;
#(
   parameter int          DATA_W = 8,
   parameter int          ADDR_W = 4,
   parameter rdw_policy_e POLICY = RDW_OLD
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [ADDR_W-1:0] raddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] rword,
   output logic [DATA_W-1:0] nxt_data,
   output logic              nxt_unk
);
   logic hit;
   assign hit = wr_en && rd_en && (waddr == raddr);

   generate
      if (POLICY == RDW_NEW) begin : g_new
         assign nxt_data = hit ? wdata : rword;
         assign nxt_unk  = 1'b0;
      end else if (POLICY == RDW_UNK) begin : g_unk
         assign nxt_data = hit ? {DATA_W{1'bx}} : rword;
         assign nxt_unk  = hit;
      end else begin : g_old
         assign nxt_data = rword;
         assign nxt_unk  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ram_rdreg.sv
module ram_rdreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   input  logic              d_unk,
   output logic [DATA_W-1:0] q,
   output logic              q_unk
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= '0;
         q_unk <= 1'b0;
      end else if (load) begin
         q     <= d;
         q_unk <= d_unk;
      end
   end

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q_unk) && (q_unk || $stable(q))); // R3
endmodule

// File: rtl/dpram_rdw.sv
module dpram_rdw
   import ram_pkg::*;
#(
   parameter int          DATA_W      = 8,
   parameter int          ADDR_W      = 4,
   parameter rdw_policy_e POLICY      = RDW_OLD,
   parameter bit          SINGLE_PORT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_unknown
);
   // new data is only trusted with one shared address
   localparam rdw_policy_e EFF_POLICY =
      (!SINGLE_PORT && POLICY == RDW_NEW) ? RDW_UNK : POLICY;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 1..16");
      end
   endgenerate

   logic [ADDR_W-1:0] raddr_eff;
   logic [DATA_W-1:0] rword;
   logic [DATA_W-1:0] nxt_data;
   logic              nxt_unk;

   generate
      if (SINGLE_PORT) begin : g_sp
         logic unused_rd_addr;
         assign unused_rd_addr = ^rd_addr;
         assign raddr_eff      = wr_addr;
      end else begin : g_dp
         assign raddr_eff = rd_addr;
      end
   endgenerate

   ram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (raddr_eff),
      .rword (rword)
   );

   ram_collide #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .POLICY(EFF_POLICY)) u_coll (
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .waddr    (wr_addr),
      .raddr    (raddr_eff),
      .wdata    (wr_data),
      .rword    (rword),
      .nxt_data (nxt_data),
      .nxt_unk  (nxt_unk)
   );

   ram_rdreg #(.DATA_W(DATA_W)) u_rreg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rd_en),
      .d     (nxt_data),
      .d_unk (nxt_unk),
      .q     (rd_data),
      .q_unk (rd_unknown)
   );

   AST_UNK_FROM_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_unknown) |-> $past(rd_en && wr_en && (raddr_eff == wr_addr))); // R7

   generate
      if (EFF_POLICY == RDW_OLD) begin : g_chk_old
         AST_OLD_NEVER_UNK: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && wr_en && raddr_eff == wr_addr) |=> !rd_unknown); // R6
      end
      if (EFF_POLICY == RDW_NEW) begin : g_chk_new
         AST_NEW_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && wr_en) |=> (rd_data == $past(wr_data)) && !rd_unknown); // R8
      end
      if (!SINGLE_PORT && POLICY == RDW_NEW) begin : g_chk_dpnew
         AST_DP_NEW_IS_UNK: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && wr_en && rd_addr == wr_addr) |=> rd_unknown); // R9
      end
   endgenerate
endmodule

// File: tb/sim_dpram_rdw.sv
`timescale 1ns/1ps
module sim_dpram_rdw;
   import ram_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       wr_en = 0, rd_en = 0;
   logic [3:0] wr_addr = 0, rd_addr = 0;
   logic [7:0] wr_data = 0;
   logic [7:0] qd [4];
   logic       qu [4];

   // 0 dual old, 1 dual unknown, 2 single new, 3 dual new (degrades)
   dpram_rdw #(.DATA_W(8), .ADDR_W(4), .POLICY(RDW_OLD), .SINGLE_PORT(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(qd[0]), .rd_unknown(qu[0]));
   dpram_rdw #(.DATA_W(8), .ADDR_W(4), .POLICY(RDW_UNK), .SINGLE_PORT(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(qd[1]), .rd_unknown(qu[1]));
   dpram_rdw #(.DATA_W(8), .ADDR_W(4), .POLICY(RDW_NEW), .SINGLE_PORT(1'b1)) u2 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(qd[2]), .rd_unknown(qu[2]));
   dpram_rdw #(.DATA_W(8), .ADDR_W(4), .POLICY(RDW_NEW), .SINGLE_PORT(1'b0)) u3 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(qd[3]), .rd_unknown(qu[3]));

   int n_chk = 0, n_bad = 0;

   // expected model, built from the requirements
   logic [7:0] mdl [4][16];
   logic [7:0] exp_d [4];
   logic       exp_u [4];
   logic       prv_u [4];

   function automatic bit is_sp(int i);  return i == 2; endfunction
   // 0 old, 1 unknown, 2 new
   function automatic int eff_pol(int i);
      return (i == 0) ? 0 : (i == 2) ? 2 : 1;
   endfunction

   task automatic chk(bit ok, string tag, int inst, logic [8:0] act, logic [8:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s u%0d: actual unk/data=%h expected=%h", tag, inst, act, expv);
      end
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // {we, wa[3:0], wd[7:0], re, ra[3:0]}
   localparam int NV = 16;
   localparam logic [17:0] VEC [NV] = '{
      {1'b0, 4'd3, 8'h00, 1'b1, 4'd3},
      {1'b1, 4'd5, 8'hA5, 1'b1, 4'd5},
      {1'b0, 4'd0, 8'h00, 1'b1, 4'd5},
      {1'b1, 4'd2, 8'h3C, 1'b1, 4'd7},
      {1'b0, 4'd2, 8'h00, 1'b1, 4'd2},
      {1'b1, 4'd9, 8'h77, 1'b0, 4'd9},
      {1'b0, 4'd0, 8'h00, 1'b0, 4'd0},
      {1'b0, 4'd9, 8'h00, 1'b1, 4'd9},
      {1'b1, 4'd9, 8'hE1, 1'b1, 4'd9},
      {1'b0, 4'd4, 8'hFF, 1'b1, 4'd4},
      {1'b1, 4'd4, 8'h11, 1'b1, 4'd4},
      {1'b1, 4'd4, 8'h22, 1'b1, 4'd4},
      {1'b0, 4'd4, 8'h00, 1'b1, 4'd4},
      {1'b1, 4'd6, 8'h5A, 1'b1, 4'd1},
      {1'b0, 4'd6, 8'h00, 1'b1, 4'd1},
      {1'b1, 4'd0, 8'hC3, 1'b1, 4'd0}
   };

   task automatic step(logic we, logic [3:0] wa, logic [7:0] wd, logic re,
                       logic [3:0] ra, bit do_chk, string force_tag);
      string tags [4];
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
      for (int i = 0; i < 4; i++) begin
         logic [3:0] ea;
         bit coll;
         ea = is_sp(i) ? wa : ra;
         coll = we && re && (ea == wa);
         prv_u[i] = exp_u[i];
         if (!re) tags[i] = "R3";
         else if (coll) begin
            if (eff_pol(i) == 0)      tags[i] = "R6";
            else if (eff_pol(i) == 2) tags[i] = "R8";
            else                      tags[i] = (i == 3) ? "R9" : "R7";
         end
         else if (prv_u[i])           tags[i] = "R11";
         else if (is_sp(i) && ra != wa) tags[i] = "R10";
         else if (we)                 tags[i] = "R5";
         else                         tags[i] = "R2";
         if (force_tag != "") tags[i] = force_tag;
         if (re) begin
            if (coll && eff_pol(i) == 1) begin
               exp_u[i] = 1'b1;
            end else begin
               exp_u[i] = 1'b0;
               exp_d[i] = (coll && eff_pol(i) == 2) ? wd : mdl[i][ea];
            end
         end
         if (we) mdl[i][wa] = wd;
      end
      @(posedge clk);
      #1;
      if (do_chk) begin
         for (int i = 0; i < 4; i++) begin
            if (exp_u[i])
               chk(qu[i] === 1'b1, tags[i], i, {qu[i], qd[i]}, {1'b1, 8'h00});
            else
               chk(qu[i] === 1'b0 && qd[i] === exp_d[i], tags[i], i,
                   {qu[i], qd[i]}, {1'b0, exp_d[i]});
         end
      end
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_up();
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         exp_d[i] = 8'h00; exp_u[i] = 1'b0; prv_u[i] = 1'b0;
      end
      repeat (3) @(posedge clk);
      #1;
      for (int i = 0; i < 4; i++)   // R1
         chk(qd[i] === 8'h00 && qu[i] === 1'b0, "R1", i, {qu[i], qd[i]}, 9'h000);
      @(negedge clk);
      rst_n = 1'b1;
      // fill every word; rd_en low so the outputs must hold their reset value (R3)
      for (int a = 0; a < 16; a++)
         step(1'b1, 4'(a), 8'h10 + 8'(a * 7), 1'b0, 4'd0, a == 15, "");
      for (int v = 0; v < NV; v++)
         step(VEC[v][17], VEC[v][16:13], VEC[v][12:5], VEC[v][4], VEC[v][3:0], 1'b1, "");
      // R4: a write with wr_en low must leave word 4 unchanged
      step(1'b0, 4'd4, 8'hEE, 1'b1, 4'd8, 1'b1, "");
      step(1'b0, 4'd4, 8'h00, 1'b1, 4'd4, 1'b1, "R4");
      // R7: after an unknown collision the written value is readable
      step(1'b1, 4'd11, 8'h6B, 1'b1, 4'd11, 1'b1, "");
      step(1'b0, 4'd11, 8'h00, 1'b0, 4'd11, 1'b1, "R3");
      step(1'b0, 4'd11, 8'h00, 1'b1, 4'd11, 1'b1, "R7");
      finish_up();
   end
endmodule